// File: doc/BRIEF.md
# HDLC Transmit Message Buffer with Repeat Mode

This block is a byte-wide staging buffer placed between a host write port and a bit-level HDLC transmitter. The host writes message bytes and tags the final byte of each message with an end-of-message strobe, so the buffer can hold several whole messages at once. The transmitter pulls bytes one at a time and receives start-of-message and end-of-message markers with each byte. Flag insertion, bit stuffing and CRC are done downstream.

The host sees a free-space count telling it how many bytes it may still write without loss. It also sees a fill-level status that is raised when the stored bytes drop below one of eight selectable thresholds, with a maskable interrupt. Storage of a message is given back only after its last byte has been handed to the transmitter. With repeat mode on, a message whose last byte has just gone out is replayed from its first byte for as long as no further complete message is waiting behind it. This suits links that must keep sending a filler frame between real traffic. Once a new complete message is waiting, the current repetition runs to its end and the new message follows.

The read side is a three-state machine. IDLE means no message is in progress and the read point sits on a message's first byte. SEND means part of a message has been taken for the first time. REPEAT means the held message is being replayed. IDLE goes to SEND when a non-final byte is taken. IDLE or SEND go to REPEAT when a final byte is taken with repeat mode on and no other complete message queued. Otherwise they go to IDLE. REPEAT stays in REPEAT by rewinding at the final byte while repeat mode is on and nothing is queued. Otherwise REPEAT goes to IDLE and frees the held message. The transmit reset sends every state to IDLE.

Top module: `hdlc_tx_msgbuf`

## Requirements
- R1: After reset, free_cnt is 128, tx_avail is 0, tx_abort and tx_underrun are 0, and lwm_flag is 1 because zero bytes are below every threshold.
- R2: A write with wr_en stores wr_data together with the wr_eom tag. A write made while free_cnt is 0 is dropped and has no effect on free_cnt or on the bytes later read out.
- R3: free_cnt equals 128 minus the bytes held. The bytes of a message stay held until its last byte has been taken. free_cnt changes in the cycle after the write or take.
- R4: While tx_avail is 1, tx_data shows the oldest untaken byte. tx_sof is 1 on a message's first byte and tx_eof is 1 on its last. A cycle with tx_req and tx_avail takes the byte. Messages come out in write order.
- R5: lwm_sel values 0 to 6 select a threshold of (lwm_sel+1)*16 bytes, and 7 selects 120. lwm_flag is 1 exactly when the bytes held are fewer than the threshold.
- R6: lwm_irq is 1 exactly when lwm_flag is 1 and lwm_irq_en is 1.
- R7: With loop_en set, when the last byte of a message is taken and no other complete message is stored, the same message is presented again from its first byte, repeatedly, and its bytes stay held.
- R8: While a message repeats, queued bytes without an end-of-message tag do not end the repeats. Once a complete message is queued, the running repetition finishes, the held message is freed, and the new message follows.
- R9: tx_rst empties the buffer (free_cnt 128, tx_avail 0) and cancels any repeat. tx_abort is 1 for exactly one cycle after tx_rst if at least one byte of a message had been taken but not its last; otherwise tx_abort stays 0.
- R10: tx_underrun is set when tx_req arrives while tx_avail is 0, a message is part-way sent, and loop_en is 0. It stays set until tx_rst or rst_n. A request with no message in progress, or with loop_en set, does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Synchronous transmit reset: drop all messages |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| wr_eom | input | 1 | Marks the written byte as the last of its message |
| loop_en | input | 1 | Repeat the last complete message when nothing new is queued |
| lwm_sel | input | 3 | Low fill threshold select |
| lwm_irq_en | input | 1 | Interrupt mask for the low fill status |
| free_cnt | output | 8 | Bytes the host may still write |
| lwm_flag | output | 1 | Bytes held are below the selected threshold |
| lwm_irq | output | 1 | Masked low fill interrupt |
| tx_req | input | 1 | Transmitter takes the presented byte |
| tx_avail | output | 1 | A byte is presented |
| tx_data | output | 8 | Presented byte |
| tx_sof | output | 1 | Presented byte starts a message |
| tx_eof | output | 1 | Presented byte ends a message |
| tx_abort | output | 1 | One-cycle abort after a reset that cut a message |
| tx_underrun | output | 1 | Sticky underrun status |

## Verification
The hardest case to reach from the ports is the hand-over from the repeat state to a new message. A complete message has to land while the held one is being replayed, and a half-written message must not cut the replay short. Directed sequences reach this by writing a tagless prefix of the next message during a repetition, checking that the old message still comes back from its first byte, then adding the final tagged byte and checking that the repetition finishes before the new message starts. Transmit resets are applied both mid-replay and exactly between replays to separate the abort and no-abort cases. A long random phase mixes writes and takes against a bench model of the stored bytes.

// File: rtl/hdlc_txbuf_pkg.sv
package hdlc_txbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_REPEAT = 2'd2
    } txbuf_state_e;

    // Threshold for a select code: eighths of the depth, top code one sixteenth short of full
    function automatic int unsigned lwm_level(input logic [2:0] sel, input int unsigned depth);
        if (sel == 3'd7)
            return depth - depth / 16;
        else
            return (int'(sel) + 1) * (depth / 8);
    endfunction

endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 9,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_word;
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/txbuf_lwm.sv
module txbuf_lwm
    import hdlc_txbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] fill,
    input  logic [2:0]    sel,
    input  logic          irq_en,
    output logic          flag,
    output logic          irq
);

    logic [CW-1:0] level;

    always_comb begin
        level = CW'(lwm_level(sel, DEPTH));
        flag  = (fill < level);
        irq   = flag & irq_en;
    end

endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
    import hdlc_txbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_rst,
    input  logic          wr_en,
    input  logic          wr_eom,
    input  logic          loop_en,
    input  logic          tx_req,
    input  logic          rd_eom,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] fill,
    output logic          tx_avail,
    output logic          tx_sof,
    output logic          tx_abort,
    output logic          tx_underrun
);

    txbuf_state_e  st_q, st_d;
    logic [CW-1:0] wr_q, wr_d;
    logic [CW-1:0] rd_q, rd_d;
    logic [CW-1:0] base_q, base_d;
    logic [CW-1:0] rdy_q, rdy_d;
    logic          abort_d, under_d;
    logic          pop, mid_msg, full;

    // Output process
    always_comb begin
        fill     = wr_q - base_q;
        full     = (fill == CW'(DEPTH));
        tx_avail = (st_q == ST_REPEAT) || (rd_q != wr_q);
        tx_sof   = tx_avail && (rd_q == base_q);
        mid_msg  = (st_q == ST_SEND) || ((st_q == ST_REPEAT) && (rd_q != base_q));
        wr_fire  = wr_en && !full && !tx_rst;
        pop      = tx_req && tx_avail && !tx_rst;
        wr_addr  = wr_q[AW-1:0];
        rd_addr  = rd_q[AW-1:0];
    end

    // Next-state process
    always_comb begin
        st_d    = st_q;
        wr_d    = wr_q;
        rd_d    = rd_q;
        base_d  = base_q;
        rdy_d   = rdy_q;
        abort_d = 1'b0;
        under_d = tx_underrun;
        if (wr_fire) begin
            wr_d = wr_q + 1'b1;
            if (wr_eom)
                rdy_d = rdy_q + 1'b1;
        end
        if (tx_req && !tx_avail && (st_q == ST_SEND) && !loop_en)
            under_d = 1'b1;
        if (pop) begin
            unique case (st_q)
                ST_IDLE, ST_SEND: begin
                    if (!rd_eom) begin
                        rd_d = rd_q + 1'b1;
                        st_d = ST_SEND;
                    end else begin
                        rdy_d = rdy_d - 1'b1;
                        if (loop_en && (rdy_q == CW'(1))) begin
                            rd_d = base_q;
                            st_d = ST_REPEAT;
                        end else begin
                            rd_d   = rd_q + 1'b1;
                            base_d = rd_q + 1'b1;
                            st_d   = ST_IDLE;
                        end
                    end
                end
                ST_REPEAT: begin
                    if (!rd_eom) begin
                        rd_d = rd_q + 1'b1;
                    end else if (loop_en && (rdy_q == '0)) begin
                        rd_d = base_q;
                    end else begin
                        rd_d   = rd_q + 1'b1;
                        base_d = rd_q + 1'b1;
                        st_d   = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
        if (tx_rst) begin
            st_d    = ST_IDLE;
            wr_d    = '0;
            rd_d    = '0;
            base_d  = '0;
            rdy_d   = '0;
            abort_d = mid_msg;
            under_d = 1'b0;
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            wr_q        <= '0;
            rd_q        <= '0;
            base_q      <= '0;
            rdy_q       <= '0;
            tx_abort    <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            st_q        <= st_d;
            wr_q        <= wr_d;
            rd_q        <= rd_d;
            base_q      <= base_d;
            rdy_q       <= rdy_d;
            tx_abort    <= abort_d;
            tx_underrun <= under_d;
        end
    end

endmodule

// File: rtl/hdlc_tx_msgbuf.sv
module hdlc_tx_msgbuf #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_eom,
    input  logic          loop_en,
    input  logic [2:0]    lwm_sel,
    input  logic          lwm_irq_en,
    output logic [CW-1:0] free_cnt,
    output logic          lwm_flag,
    output logic          lwm_irq,
    input  logic          tx_req,
    output logic          tx_avail,
    output logic [DW-1:0] tx_data,
    output logic          tx_sof,
    output logic          tx_eof,
    output logic          tx_abort,
    output logic          tx_underrun
);

    logic          wr_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] fill;
    logic [DW:0]   rd_word;

    txbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rst      (tx_rst),
        .wr_en       (wr_en),
        .wr_eom      (wr_eom),
        .loop_en     (loop_en),
        .tx_req      (tx_req),
        .rd_eom      (rd_word[DW]),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr),
        .rd_addr     (rd_addr),
        .fill        (fill),
        .tx_avail    (tx_avail),
        .tx_sof      (tx_sof),
        .tx_abort    (tx_abort),
        .tx_underrun (tx_underrun)
    );

    txbuf_store #(.DEPTH(DEPTH), .DW(DW + 1)) u_store (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_addr (wr_addr),
        .wr_word ({wr_eom, wr_data}),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    txbuf_lwm #(.DEPTH(DEPTH)) u_lwm (
        .fill   (fill),
        .sel    (lwm_sel),
        .irq_en (lwm_irq_en),
        .flag   (lwm_flag),
        .irq    (lwm_irq)
    );

    assign free_cnt = CW'(DEPTH) - fill;
    assign tx_data  = rd_word[DW-1:0];
    assign tx_eof   = tx_avail && rd_word[DW];

endmodule

// File: rtl/hdlc_tx_msgbuf_chk.sv
module hdlc_tx_msgbuf_chk #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_rst,
    input logic          tx_req,
    input logic          loop_en,
    input logic          lwm_irq_en,
    input logic [CW-1:0] free_cnt,
    input logic          lwm_flag,
    input logic          lwm_irq,
    input logic          tx_avail,
    input logic          tx_sof,
    input logic          tx_eof,
    input logic          tx_abort,
    input logic          tx_underrun
);

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (free_cnt == '0 && !tx_rst && !tx_req) |=> free_cnt == '0); // R2
    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) free_cnt <= CW'(DEPTH)); // R3
    AST_FREE_AT_EOM: assert property (@(posedge clk) disable iff (!rst_n) (!tx_rst && !(tx_req && tx_avail && tx_eof)) |=> free_cnt <= $past(free_cnt)); // R3
    AST_SOF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (tx_req && tx_avail && tx_eof && !tx_rst) |=> (!tx_avail || tx_sof)); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) lwm_irq |-> (lwm_flag && lwm_irq_en)); // R6
    AST_LOOP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (loop_en && tx_req && tx_avail && tx_eof && !tx_rst) |=> tx_avail); // R7
    AST_RST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_rst |=> (free_cnt == CW'(DEPTH) && !tx_avail && !tx_underrun)); // R9
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tx_abort |=> !tx_abort); // R9
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (tx_underrun && !tx_rst) |=> tx_underrun); // R10

endmodule

bind hdlc_tx_msgbuf hdlc_tx_msgbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_rst      (tx_rst),
    .tx_req      (tx_req),
    .loop_en     (loop_en),
    .lwm_irq_en  (lwm_irq_en),
    .free_cnt    (free_cnt),
    .lwm_flag    (lwm_flag),
    .lwm_irq     (lwm_irq),
    .tx_avail    (tx_avail),
    .tx_sof      (tx_sof),
    .tx_eof      (tx_eof),
    .tx_abort    (tx_abort),
    .tx_underrun (tx_underrun)
);

// File: tb/test_hdlc_tx_msgbuf.sv
`timescale 1ns/1ps
module test_hdlc_tx_msgbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eom = 1'b0;
    logic       loop_en = 1'b0;
    logic [2:0] lwm_sel = '0;
    logic       lwm_irq_en = 1'b0;
    logic       tx_req = 1'b0;
    logic [7:0] free_cnt;
    logic       lwm_flag, lwm_irq, tx_avail, tx_sof, tx_eof, tx_abort, tx_underrun;
    logic [7:0] tx_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_tx_msgbuf i_hdlc_tx_msgbuf (
        .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eom(wr_eom), .loop_en(loop_en), .lwm_sel(lwm_sel), .lwm_irq_en(lwm_irq_en),
        .free_cnt(free_cnt), .lwm_flag(lwm_flag), .lwm_irq(lwm_irq), .tx_req(tx_req),
        .tx_avail(tx_avail), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_abort(tx_abort), .tx_underrun(tx_underrun)
    );

    function automatic int lvl(input int s);
        return (s == 7) ? 120 : (s + 1) * 16;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int d, input bit e);
        wr_en = 1'b1; wr_data = d[7:0]; wr_eom = e;
        tick();
        wr_en = 1'b0; wr_eom = 1'b0;
    endtask

    task automatic take(input string tag, input int d, input bit s, input bit e);
        chk({tag, " avail"}, int'(tx_avail), 1);
        chk({tag, " data"}, int'(tx_data), d);
        chk({tag, " sof"}, int'(tx_sof), int'(s));
        chk({tag, " eof"}, int'(tx_eof), int'(e));
        tx_req = 1'b1;
        tick();
        tx_req = 1'b0;
    endtask

    task automatic xrst();
        tx_rst = 1'b1;
        tick();
        tx_rst = 1'b0;
    endtask

    // bench model for the random phase
    int mdat [256];
    bit meom [256];
    int hd, tl, ms;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1D5C);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 free", int'(free_cnt), 128);
        chk("R1 avail", int'(tx_avail), 0);
        chk("R1 abort", int'(tx_abort), 0);
        chk("R1 underrun", int'(tx_underrun), 0);
        chk("R1 lwm", int'(lwm_flag), 1);

        // R5 thresholds and R3 free count while filling
        for (int f = 1; f <= 120; f++) begin
            wr((f * 7 + 3) & 255, f == 120);
            chk("R3 fill free", int'(free_cnt), 128 - f);
            for (int s = 0; s < 8; s++) begin
                lwm_sel = 3'(s);
                #0.1;
                chk("R5 lwm level", int'(lwm_flag), int'(f < lvl(s)));
            end
            if (f == 10 || f == 20) begin
                lwm_sel = 3'd0; lwm_irq_en = 1'b1; #0.1;
                chk("R6 irq on", int'(lwm_irq), int'(f < 16));
                lwm_irq_en = 1'b0; #0.1;
                chk("R6 irq masked", int'(lwm_irq), 0);
            end
        end
        // R4 drain, R3 bytes held until last byte taken
        for (int i = 0; i < 120; i++) begin
            take("R4 drain", ((i + 1) * 7 + 3) & 255, i == 0, i == 119);
            if (i < 119) chk("R3 held", int'(free_cnt), 8);
        end
        chk("R3 freed", int'(free_cnt), 128);
        chk("R4 empty", int'(tx_avail), 0);

        // R2 full buffer drops extra write
        for (int i = 0; i < 128; i++) wr(i ^ 8'h5A, i == 127);
        chk("R2 full", int'(free_cnt), 0);
        wr(8'hEE, 1'b1);
        chk("R2 full after drop", int'(free_cnt), 0);
        for (int i = 0; i < 128; i++) take("R2 drain", i ^ 8'h5A, i == 0, i == 127);
        chk("R2 dropped byte absent", int'(tx_avail), 0);
        chk("R2 free", int'(free_cnt), 128);

        // R4 several messages in order
        wr(8'h01, 0); wr(8'h02, 1); wr(8'h03, 1); wr(8'h04, 0); wr(8'h05, 0); wr(8'h06, 1);
        take("R4 m1", 1, 1, 0); take("R4 m1", 2, 0, 1);
        chk("R4 m1 freed", int'(free_cnt), 124);
        take("R4 m2", 3, 1, 1);
        take("R4 m3", 4, 1, 0); take("R4 m3", 5, 0, 0); take("R4 m3", 6, 0, 1);
        chk("R4 done", int'(tx_avail), 0);

        // R10 request when idle and empty
        tx_req = 1'b1; tick(); tx_req = 1'b0;
        chk("R10 idle request", int'(tx_underrun), 0);
        // R10 underrun mid-message
        wr(8'h11, 0); wr(8'h22, 0);
        take("R10 pre", 8'h11, 1, 0); take("R10 pre", 8'h22, 0, 0);
        tx_req = 1'b1; tick(); tx_req = 1'b0;
        chk("R10 underrun set", int'(tx_underrun), 1);
        tick();
        chk("R10 underrun sticky", int'(tx_underrun), 1);
        xrst();
        chk("R9 abort mid message", int'(tx_abort), 1);
        chk("R10 cleared by tx_rst", int'(tx_underrun), 0);
        chk("R9 free", int'(free_cnt), 128);
        tick();
        chk("R9 abort one cycle", int'(tx_abort), 0);
        // R10 no underrun with loop on
        loop_en = 1'b1;
        wr(8'h33, 0);
        take("R10 loop pre", 8'h33, 1, 0);
        tx_req = 1'b1; tick(); tx_req = 1'b0;
        chk("R10 loop no underrun", int'(tx_underrun), 0);
        xrst();

        // R7 repeat of last message
        wr(8'hA0, 0); wr(8'hA1, 0); wr(8'hA2, 1);
        take("R7 first", 8'hA0, 1, 0); take("R7 first", 8'hA1, 0, 0); take("R7 first", 8'hA2, 0, 1);
        chk("R7 held", int'(free_cnt), 125);
        for (int r = 0; r < 2; r++) begin
            take("R7 repeat", 8'hA0, 1, 0); take("R7 repeat", 8'hA1, 0, 0); take("R7 repeat", 8'hA2, 0, 1);
        end
        // R8 partial next message does not stop repeats
        wr(8'hB0, 0); wr(8'hB1, 0);
        take("R8 partial", 8'hA0, 1, 0); take("R8 partial", 8'hA1, 0, 0); take("R8 partial", 8'hA2, 0, 1);
        chk("R8 partial held", int'(free_cnt), 123);
        take("R8 rep", 8'hA0, 1, 0);
        wr(8'hB2, 1);
        take("R8 finish", 8'hA1, 0, 0); take("R8 finish", 8'hA2, 0, 1);
        chk("R8 old freed", int'(free_cnt), 125);
        take("R8 new", 8'hB0, 1, 0); take("R8 new", 8'hB1, 0, 0); take("R8 new", 8'hB2, 0, 1);
        take("R7 new repeats", 8'hB0, 1, 0);
        loop_en = 1'b0;
        take("R7 stop", 8'hB1, 0, 0); take("R7 stop", 8'hB2, 0, 1);
        chk("R7 stopped", int'(tx_avail), 0);
        chk("R7 stopped free", int'(free_cnt), 128);

        // R9 reset mid repeat
        loop_en = 1'b1;
        wr(8'hC0, 0); wr(8'hC1, 0); wr(8'hC2, 1);
        take("R9 a", 8'hC0, 1, 0); take("R9 a", 8'hC1, 0, 0); take("R9 a", 8'hC2, 0, 1);
        take("R9 a", 8'hC0, 1, 0);
        xrst();
        chk("R9 abort in repeat", int'(tx_abort), 1);
        chk("R9 repeat cancelled", int'(tx_avail), 0);
        chk("R9 free after", int'(free_cnt), 128);
        tick();
        // single byte message repeats; reset between repeats gives no abort
        wr(8'hD5, 1);
        take("R7 single", 8'hD5, 1, 1);
        take("R7 single rep", 8'hD5, 1, 1);
        xrst();
        chk("R9 no abort between repeats", int'(tx_abort), 0);
        chk("R9 empty", int'(tx_avail), 0);
        loop_en = 1'b0;
        tick();

        // random phase, loop off
        hd = 0; tl = 0; ms = 0;
        for (int n = 0; n < 4000; n++) begin
            bit dw, dr, de;
            int dd, fr, sl;
            fr = 128 - (tl - ms);
            dw = ($urandom % 3) != 0;
            dr = (($urandom % 2) == 1) && (hd < tl);
            dd = int'($urandom % 256);
            de = (($urandom % 6) == 0) || (fr <= 1);
            sl = int'($urandom % 8);
            lwm_sel = 3'(sl);
            #0.1;
            chk("R5 random lwm", int'(lwm_flag), int'((tl - ms) < lvl(sl)));
            chk("R4 random avail", int'(tx_avail), int'(hd < tl));
            if (hd < tl) begin
                chk("R4 random data", int'(tx_data), mdat[hd % 256]);
                chk("R4 random sof", int'(tx_sof), int'(hd == ms));
                chk("R4 random eof", int'(tx_eof), int'(meom[hd % 256]));
            end
            wr_en = dw; wr_data = dd[7:0]; wr_eom = de; tx_req = dr;
            tick();
            wr_en = 1'b0; wr_eom = 1'b0; tx_req = 1'b0;
            if (dr) begin
                if (meom[hd % 256]) ms = hd + 1;
                hd++;
            end
            if (dw && fr > 0) begin
                mdat[tl % 256] = dd;
                meom[tl % 256] = de;
                tl++;
            end
            chk("R3 random free", int'(free_cnt), 128 - (tl - ms));
        end
        chk("R10 random no underrun", int'(tx_underrun), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule